// File: doc/BRIEF.md
# Compressed Audio Burst Sync Detector

This block sits behind the subframe decoder of a consumer digital audio receiver. It watches the 16-bit payload word carried in each received subframe and looks for the two-word sync pattern that opens a compressed (non-PCM) data burst. The pattern is 16'hF872 followed by 16'h4E1F. Once both sync words have been seen on successive valid subframes, the next two valid words are taken as the burst information word and the burst length word. When the burst is registered, the block raises its detect flag and keeps both words in output registers. It also presents the five-bit payload type carried in the low bits of the information word.

A frame strobe drives a timeout. If no further burst completes within a set number of frames (4096 by default), the flag drops and both held words return to zero. A one-cycle change pulse tells downstream logic that the held information word has changed. Typical users are the audio path mute control and the decoder selection logic.

Top module: `burst_sync_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared: `burst_found`, `burst_info`, `burst_len`, `burst_kind` and `info_changed` all read 0 after that edge.
- R2: A valid word equal to 16'hF872, followed on the next valid word by 16'h4E1F, makes the next two valid words the information and length words. If the fourth word is sampled at edge k, then after edge k+1 `burst_found` is 1, `burst_info` holds the third word and `burst_len` holds the fourth word.
- R3: Cycles with `word_vld` low are ignored by the sequence search. Idle cycles between any of the four words neither break nor advance a detection.
- R4: A valid word other than 16'h4E1F that directly follows 16'hF872 restarts the search. The words after it are not captured unless a full new pattern appears.
- R5: When 16'hF872 arrives where 16'h4E1F was expected, it is taken at once as a new first sync word. So the sequence F872, F872, 4E1F, x, y is detected with x and y captured.
- R6: `burst_kind` always equals bits 4:0 of `burst_info`. The codes are 0 null, 1 AC-3, 2 reserved, 3 pause, 4 MPEG-1 layer 1, 5 MPEG-1 layer 2/3 or MPEG-2 without extension, and 6 MPEG-2 with extension.
- R7: `info_changed` is high for exactly one cycle, in the same cycle that a newly registered burst makes `burst_info` differ from its previous value. It stays low when a new burst carries the same information word.
- R8: With the flag set, the 4096th `frame_tick` after a burst is registered clears `burst_found`, `burst_info` and `burst_len` after that edge, and pulses `info_changed` for one cycle. After 4095 ticks the flag is still set.
- R9: Each newly registered burst restarts the frame count from zero.
- R10: While the flag is clear, `frame_tick` has no effect. No change pulse fires and all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Strobe marking a received subframe payload word |
| word_in | input | 16 | Payload word of the current subframe |
| frame_tick | input | 1 | One pulse per received frame |
| burst_found | output | 1 | Compressed burst detected and timeout not yet expired |
| burst_info | output | 16 | Held burst information word |
| burst_len | output | 16 | Held burst length word |
| burst_kind | output | 5 | Payload type code, bits 4:0 of the information word |
| info_changed | output | 1 | One-cycle pulse when the held information word changes |

## Verification
A search state stuck past the first sync word shows up within one burst: a rotated or doubled sync sequence is then missed, or junk is captured as the information word. Both appear two cycles after the fourth word. A frame counter that fails to restart or miscounts shows up only at the frame limit, so the bench counts the exact tick on which the flag drops, with and without an intervening burst. A stale comparison register shows up as a change pulse that is missing or extra on a repeated or new information word.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned KIND_W  = 5;
  localparam logic [WORD_W-1:0] SYNC_FIRST  = 16'hF872;
  localparam logic [WORD_W-1:0] SYNC_SECOND = 16'h4E1F;

  typedef enum logic [1:0] {
    SEEK_A = 2'd0,
    SEEK_B = 2'd1,
    GRAB_C = 2'd2,
    GRAB_D = 2'd3
  } seek_t;
endpackage

// File: rtl/burst_seq_matcher.sv
module burst_seq_matcher
  import burst_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] SYNC_A = SYNC_FIRST,
  parameter logic [W-1:0] SYNC_B = SYNC_SECOND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         word_vld,
  input  logic [W-1:0] word_in,
  output logic         hit,
  output logic [W-1:0] hit_info,
  output logic [W-1:0] hit_len
);
  seek_t        state_q;
  logic [W-1:0] info_tmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEEK_A;
      info_tmp_q <= '0;
      hit        <= 1'b0;
      hit_info   <= '0;
      hit_len    <= '0;
    end else begin
      hit <= 1'b0;
      if (word_vld) begin
        unique case (state_q)
          SEEK_A: state_q <= (word_in == SYNC_A) ? SEEK_B : SEEK_A;
          SEEK_B: begin
            // a repeated first sync word restarts the pair without lag
            if (word_in == SYNC_B)      state_q <= GRAB_C;
            else if (word_in == SYNC_A) state_q <= SEEK_B;
            else                        state_q <= SEEK_A;
          end
          GRAB_C: begin
            info_tmp_q <= word_in;
            state_q    <= GRAB_D;
          end
          GRAB_D: begin
            hit      <= 1'b1;
            hit_info <= info_tmp_q;
            hit_len  <= word_in;
            state_q  <= SEEK_A;
          end
          default: state_q <= SEEK_A;
        endcase
      end
    end
  end

  // R2: a burst completes on a single cycle, never back to back
  p_hit_single_r2: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  // R3: a completion is always caused by a valid word
  p_hit_needs_word_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(word_vld));
endmodule

// File: rtl/burst_frame_timer.sv
module burst_frame_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic frame_tick,
  output logic expire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign expire = armed_q && frame_tick && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (expire) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && frame_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: a new burst restarts the count from zero
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (armed_q && cnt_q == '0));
  // R8: each frame advances the count by exactly one until the limit
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && frame_tick && !restart && !expire) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10: frames while idle leave the count at zero
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector
  import burst_pkg::*;
#(
  parameter int unsigned W           = WORD_W,
  parameter int unsigned FRAME_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [W-1:0]      word_in,
  input  logic              frame_tick,
  output logic              burst_found,
  output logic [W-1:0]      burst_info,
  output logic [W-1:0]      burst_len,
  output logic [KIND_W-1:0] burst_kind,
  output logic              info_changed
);
  logic         hit;
  logic [W-1:0] hit_info;
  logic [W-1:0] hit_len;
  logic         expire;

  burst_seq_matcher #(.W(W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word_in  (word_in),
    .hit      (hit),
    .hit_info (hit_info),
    .hit_len  (hit_len)
  );

  burst_frame_timer #(.LIMIT(FRAME_LIMIT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .restart    (hit),
    .frame_tick (frame_tick),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_found  <= 1'b0;
      burst_info   <= '0;
      burst_len    <= '0;
      info_changed <= 1'b0;
    end else begin
      info_changed <= 1'b0;
      if (hit) begin
        burst_found  <= 1'b1;
        burst_info   <= hit_info;
        burst_len    <= hit_len;
        info_changed <= (hit_info != burst_info);
      end else if (expire) begin
        burst_found  <= 1'b0;
        burst_info   <= '0;
        burst_len    <= '0;
        info_changed <= 1'b1;
      end
    end
  end

  assign burst_kind = burst_info[KIND_W-1:0];

  // R8: with the flag clear, both held words read zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !burst_found |-> (burst_info == '0 && burst_len == '0));
  // R7: a change pulse needs a new information word or a timeout clear
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
    info_changed |-> ((burst_info != $past(burst_info)) || $fell(burst_found)));
  // R1: the cycle after reset shows a cleared flag and no pulse
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!burst_found && !info_changed));
endmodule

// File: tb/burst_sync_detector_test.sv
module burst_sync_detector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic        frame_tick = 1'b0;
  logic        burst_found;
  logic [15:0] burst_info;
  logic [15:0] burst_len;
  logic [4:0]  burst_kind;
  logic        info_changed;

  int tests = 0;
  int fails = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  burst_sync_detector uut (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .frame_tick(frame_tick), .burst_found(burst_found), .burst_info(burst_info),
    .burst_len(burst_len), .burst_kind(burst_kind), .info_changed(info_changed)
  );

  always @(negedge clk) if (info_changed) pulses++;

  localparam logic [15:0] SA = 16'hF872;
  localparam logic [15:0] SB = 16'h4E1F;

  // {info, len, expected change pulse}
  localparam logic [32:0] VEC [6] = '{
    {16'h0001, 16'h1800, 1'b1},
    {16'h0001, 16'h1800, 1'b0},
    {16'h0005, 16'h0900, 1'b1},
    {16'h0003, 16'h0040, 1'b1},
    {16'h0006, 16'h2222, 1'b1},
    {16'h1F04, 16'hABCD, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk); word_vld = 1'b1; word_in = w;
    @(negedge clk); word_vld = 1'b0; word_in = '0;
  endtask

  task automatic send_burst(input logic [15:0] c, input logic [15:0] d);
    send_word(SA); send_word(SB); send_word(c); send_word(d);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); frame_tick = 1'b1;
    repeat (n) @(negedge clk);
    frame_tick = 1'b0;
  endtask

  initial begin
    #(150000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 found", burst_found, 0);
    chk("R1 info", burst_info, 0);
    chk("R1 len", burst_len, 0);
    chk("R1 kind", burst_kind, 0);
    chk("R1 pulse", info_changed, 0);
    rst = 1'b0;

    // R10 frames while idle have no effect
    p0 = pulses;
    ticks(5000);
    @(negedge clk);
    chk("R10 found", burst_found, 0);
    chk("R10 pulses", pulses, p0);
    chk("R10 info", burst_info, 0);

    // R2 R6 R7 table of bursts
    for (int i = 0; i < 6; i++) begin
      send_burst(VEC[i][32:17], VEC[i][16:1]);
      @(negedge clk);
      chk("R2 found", burst_found, 1);
      chk("R2 info", burst_info, VEC[i][32:17]);
      chk("R2 len", burst_len, VEC[i][16:1]);
      chk("R6 kind", burst_kind, VEC[i][21:17]);
      chk("R7 pulse", info_changed, VEC[i][0]);
      @(negedge clk);
      chk("R7 pulse width", info_changed, 0);
    end

    // R8 timeout boundary
    ticks(4095);
    chk("R8 still set at 4095", burst_found, 1);
    ticks(1);
    chk("R8 cleared", burst_found, 0);
    chk("R8 info zero", burst_info, 0);
    chk("R8 len zero", burst_len, 0);
    chk("R8 pulse", info_changed, 1);
    @(negedge clk);
    chk("R8 pulse width", info_changed, 0);

    // R9 new burst restarts the count
    send_burst(16'h0001, 16'h0010);
    @(negedge clk);
    chk("R9 first", burst_found, 1);
    ticks(3000);
    send_burst(16'h0001, 16'h0010);
    @(negedge clk);
    chk("R7 same info no pulse", info_changed, 0);
    ticks(3000);
    chk("R9 survives 6000", burst_found, 1);
    ticks(1095);
    chk("R9 set at 4095 after restart", burst_found, 1);
    ticks(1);
    chk("R9 cleared at 4096", burst_found, 0);

    // R4 mismatch after the first sync word
    send_word(SA); send_word(16'h1234); send_word(SB);
    send_word(16'h0005); send_word(16'h0007);
    repeat (2) @(negedge clk);
    chk("R4 no detect", burst_found, 0);
    chk("R4 info", burst_info, 0);

    // R5 repeated first sync word resyncs at once
    send_word(SA); send_word(SA); send_word(SB);
    send_word(16'h0003); send_word(16'h0011);
    @(negedge clk);
    chk("R5 found", burst_found, 1);
    chk("R5 info", burst_info, 16'h0003);
    chk("R5 len", burst_len, 16'h0011);

    // R3 idle cycles between words
    send_word(SA); repeat (3) @(negedge clk);
    send_word(SB); repeat (2) @(negedge clk);
    send_word(16'h0006); @(negedge clk);
    send_word(16'h0099);
    @(negedge clk);
    chk("R3 info", burst_info, 16'h0006);
    chk("R3 len", burst_len, 16'h0099);
    chk("R3 pulse", info_changed, 1);

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid found", burst_found, 0);
    chk("R1 mid info", burst_info, 0);
    chk("R1 mid len", burst_len, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule